// File: doc/BRIEF.md
# Stereo Attenuation Command Decoder

This block sits behind a serial-bus byte receiver in a two-channel volume stage. It takes each received command byte, with a valid strobe, and a pulse that marks the end of the bus transaction. From these it maintains a left and a right attenuation value in whole decibels (0 to 79) and a mute flag per channel. Those values drive the analog attenuator, which is outside this block.

An attenuation setting is split across two command bytes: a tens step (0 to 70 dB) and a units step (0 to 9 dB). A byte can address both channels, the left only or the right only. The block holds the first half of a pair until its partner arrives. It commits the sum only when both halves target the same channels within one transaction, in either order. A half that is orphaned by a transaction end, or displaced by another attenuation code, is dropped and flagged with a one-cycle error pulse. Clear and mute commands act at once and leave a pending half untouched.

Top module: `stereo_atten_decoder`

## Requirements
- R1: After reset both attenuation outputs are 0, both mute outputs are 0 and the error output is 0.
- R2: Units codes are 1101_aaaa for both channels, 1010_aaaa for the left channel and 0010_aaaa for the right channel, where aaaa is 0 to 9 dB.
- R3: Tens codes are 1110_0bbb for both channels, 1011_0bbb for the left channel and 0011_0bbb for the right channel, where bbb counts 10 dB steps.
- R4: When a tens code and a units code for the same channel selection arrive in one transaction, in either order, each selected channel's attenuation becomes 10*bbb+aaaa on the cycle after the second byte. Unselected channels do not change. A lone half changes nothing.
- R5: If a half pair is pending when the transaction end pulse arrives, it is discarded and the error output pulses high for one cycle on the following cycle. No attenuation changes.
- R6: An attenuation code that does not complete the pending half pulses the error output on the following cycle, because it is of the same kind or targets a different selection. The old half is discarded and the new code becomes the pending half.
- R7: Units codes with aaaa from 10 to 15 are ignored. The pending half, the outputs and the error output are unaffected.
- R8: Byte 1111_0000 sets both attenuations and both mute flags to 0 on the next cycle. A pending half is kept.
- R9: Byte 0111_11cc sets the left mute to cc[1] and the right mute to cc[0] on the next cycle. A pending half is kept.
- R10: A byte that arrives in the same cycle as the transaction end pulse is processed before the end. If it completes a pair, the pair commits and no error is raised.
- R11: Any other byte value has no effect on outputs or on the pending half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | A command byte is present this cycle |
| byte_i | input | 8 | Command byte |
| stop_i | input | 1 | End-of-transaction pulse |
| atten_l_o | output | 7 | Left attenuation in dB |
| atten_r_o | output | 7 | Right attenuation in dB |
| mute_l_o | output | 1 | Left mute |
| mute_r_o | output | 1 | Right mute |
| pair_err_o | output | 1 | One-cycle pulse when a half pair is discarded |

## Verification
Two events can land on the same clock edge: the byte that completes a pair and the transaction end that would otherwise orphan its partner. The bench provokes this on every odd units value of a full sweep over selection, tens value, units value and byte order. It expects the commit to land with no error pulse. The bench also sends a lone half together with the end pulse and expects the error pulse and unchanged attenuation.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int NUM_CH     = 2;
  localparam int TENS_W     = 3;
  localparam int UNITS_W    = 4;
  localparam int UNITS_MAX  = 9;
  localparam int TENS_SCALE = 10;
  localparam int ATT_MAX    = (2**TENS_W - 1) * TENS_SCALE + UNITS_MAX;
  localparam int ATT_W      = $clog2(ATT_MAX + 1);
  localparam int CH_L       = 0;
  localparam int CH_R       = 1;

  typedef enum logic [2:0] {
    K_NONE, K_TENS, K_UNITS, K_CLEAR, K_MUTE
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e           kind;
    logic [NUM_CH-1:0]   mask;   // bit CH_L, bit CH_R
    logic [UNITS_W-1:0]  val;
  } cmd_t;
endpackage

// File: rtl/sad_cmd_decode.sv
module sad_cmd_decode
  import sad_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  localparam logic [NUM_CH-1:0] M_BOTH  = '1;
  localparam logic [NUM_CH-1:0] M_LEFT  = NUM_CH'(1) << CH_L;
  localparam logic [NUM_CH-1:0] M_RIGHT = NUM_CH'(1) << CH_R;

  logic units_ok;
  assign units_ok = (int'(byte_i[UNITS_W-1:0]) <= UNITS_MAX);

  always_comb begin
    cmd_o = '{kind: K_NONE, mask: '0, val: '0};
    if (valid_i) begin
      casez (byte_i)
        8'b1101_????: if (units_ok) cmd_o = '{K_UNITS, M_BOTH,  byte_i[UNITS_W-1:0]};
        8'b1010_????: if (units_ok) cmd_o = '{K_UNITS, M_LEFT,  byte_i[UNITS_W-1:0]};
        8'b0010_????: if (units_ok) cmd_o = '{K_UNITS, M_RIGHT, byte_i[UNITS_W-1:0]};
        8'b1110_0???: cmd_o = '{K_TENS, M_BOTH,  UNITS_W'(byte_i[TENS_W-1:0])};
        8'b1011_0???: cmd_o = '{K_TENS, M_LEFT,  UNITS_W'(byte_i[TENS_W-1:0])};
        8'b0011_0???: cmd_o = '{K_TENS, M_RIGHT, UNITS_W'(byte_i[TENS_W-1:0])};
        8'b1111_0000: cmd_o = '{K_CLEAR, M_BOTH, '0};
        // cc[1] -> left, cc[0] -> right
        8'b0111_11??: begin
          cmd_o.kind       = K_MUTE;
          cmd_o.mask[CH_L] = byte_i[1];
          cmd_o.mask[CH_R] = byte_i[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sad_pair_track.sv
module sad_pair_track
  import sad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cmd_t               cmd_i,
  input  logic               stop_i,
  output logic               commit_o,
  output logic [NUM_CH-1:0]  commit_mask_o,
  output logic [TENS_W-1:0]  tens_o,
  output logic [UNITS_W-1:0] units_o,
  output logic               err_o
);
  logic               pend_q, pend_d;
  logic               ptens_q, ptens_d;
  logic [NUM_CH-1:0]  pmask_q, pmask_d;
  logic [UNITS_W-1:0] pval_q, pval_d;
  logic               err_d;
  logic               is_att, new_tens, match;

  always_comb begin
    new_tens = (cmd_i.kind == K_TENS);
    is_att   = new_tens || (cmd_i.kind == K_UNITS);
    match    = is_att && pend_q && (new_tens != ptens_q) && (cmd_i.mask == pmask_q);
    pend_d  = pend_q;
    ptens_d = ptens_q;
    pmask_d = pmask_q;
    pval_d  = pval_q;
    err_d   = 1'b0;
    if (is_att) begin
      if (match) begin
        pend_d = 1'b0;
      end else begin
        err_d   = pend_q;
        pend_d  = 1'b1;
        ptens_d = new_tens;
        pmask_d = cmd_i.mask;
        pval_d  = cmd_i.val;
      end
    end
    // byte in the same cycle is ordered before the end of transaction
    if (stop_i) begin
      if (pend_d) err_d = 1'b1;
      pend_d = 1'b0;
    end
  end

  assign commit_o      = match;
  assign commit_mask_o = pmask_q;
  assign tens_o        = ptens_q ? pval_q[TENS_W-1:0] : cmd_i.val[TENS_W-1:0];
  assign units_o       = ptens_q ? cmd_i.val : pval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      ptens_q <= 1'b0;
      pmask_q <= '0;
      pval_q  <= '0;
      err_o   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ptens_q <= ptens_d;
      pmask_q <= pmask_d;
      pval_q  <= pval_d;
      err_o   <= err_d;
    end
  end

  // R5
  stop_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pend_q);
  // R5
  stop_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && pend_q && !is_att) |=> err_o);
  // R10
  commit_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !err_o);
  // R7
  units_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.kind == K_UNITS) |-> (int'(cmd_i.val) <= UNITS_MAX));
  // R8
  clear_keeps_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.kind == K_CLEAR && !stop_i) |=> $stable(pend_q));
endmodule

// File: rtl/sad_chan_regs.sv
module sad_chan_regs
  import sad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               commit_i,
  input  logic [TENS_W-1:0]  tens_i,
  input  logic [UNITS_W-1:0] units_i,
  input  logic               mute_set_i,
  input  logic               mute_i,
  output logic [ATT_W-1:0]   atten_o,
  output logic               mute_o
);
  logic [ATT_W-1:0] sum;
  assign sum = ATT_W'(tens_i) * ATT_W'(TENS_SCALE) + ATT_W'(units_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atten_o <= '0;
      mute_o  <= 1'b0;
    end else if (clear_i) begin
      atten_o <= '0;
      mute_o  <= 1'b0;
    end else begin
      if (commit_i)   atten_o <= sum;
      if (mute_set_i) mute_o  <= mute_i;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (atten_o == '0) && !mute_o);
  // R4
  atten_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(atten_o) <= ATT_MAX);
  // R4
  atten_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clear_i) |=> $stable(atten_o));
  // R9
  mute_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_set_i && !clear_i) |=> $stable(mute_o));
endmodule

// File: rtl/stereo_atten_decoder.sv
module stereo_atten_decoder
  import sad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             stop_i,
  output logic [ATT_W-1:0] atten_l_o,
  output logic [ATT_W-1:0] atten_r_o,
  output logic             mute_l_o,
  output logic             mute_r_o,
  output logic             pair_err_o
);
  cmd_t               cmd;
  logic               commit;
  logic [NUM_CH-1:0]  commit_mask;
  logic [TENS_W-1:0]  tens;
  logic [UNITS_W-1:0] units;
  logic [ATT_W-1:0]   atten [NUM_CH];
  logic [NUM_CH-1:0]  mute;

  sad_cmd_decode u_dec (
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .cmd_o   (cmd)
  );

  sad_pair_track u_pair (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .stop_i        (stop_i),
    .commit_o      (commit),
    .commit_mask_o (commit_mask),
    .tens_o        (tens),
    .units_o       (units),
    .err_o         (pair_err_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sad_chan_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (cmd.kind == K_CLEAR),
      .commit_i   (commit && commit_mask[ch]),
      .tens_i     (tens),
      .units_i    (units),
      .mute_set_i (cmd.kind == K_MUTE),
      .mute_i     (cmd.mask[ch]),
      .atten_o    (atten[ch]),
      .mute_o     (mute[ch])
    );
  end

  assign atten_l_o = atten[CH_L];
  assign atten_r_o = atten[CH_R];
  assign mute_l_o  = mute[CH_L];
  assign mute_r_o  = mute[CH_R];
endmodule

// File: tb/tb_stereo_atten_decoder.sv
module tb_stereo_atten_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       stop_i = 1'b0;
  logic [6:0] atten_l_o, atten_r_o;
  logic       mute_l_o, mute_r_o, pair_err_o;

  int vec = 0, bad = 0;
  bit done = 0;
  int exp_l = 0, exp_r = 0;
  bit exp_ml = 0, exp_mr = 0;

  always #4 clk = ~clk;

  stereo_atten_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .stop_i(stop_i), .atten_l_o(atten_l_o), .atten_r_o(atten_r_o),
    .mute_l_o(mute_l_o), .mute_r_o(mute_r_o), .pair_err_o(pair_err_o)
  );

  task automatic check(input bit eerr, input string tag);
    vec++;
    if (int'(atten_l_o) != exp_l || int'(atten_r_o) != exp_r || mute_l_o != exp_ml ||
        mute_r_o != exp_mr || pair_err_o != eerr) begin
      bad++;
      $display("FAIL %s: act L=%0d R=%0d ml=%0b mr=%0b err=%0b exp L=%0d R=%0d ml=%0b mr=%0b err=%0b",
               tag, atten_l_o, atten_r_o, mute_l_o, mute_r_o, pair_err_o,
               exp_l, exp_r, exp_ml, exp_mr, eerr);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit s, input bit eerr,
                      input string tag);
    @(negedge clk);
    byte_valid_i = v; byte_i = b; stop_i = s;
    @(posedge clk); #1;
    byte_valid_i = 1'b0; stop_i = 1'b0;
    check(eerr, tag);
  endtask

  task automatic set_exp(input int sel, input int val);
    if (sel != 2) exp_l = val;
    if (sel != 1) exp_r = val;
  endtask

  localparam logic [7:0] TENS_B[3]  = '{8'hE0, 8'hB0, 8'h30};
  localparam logic [7:0] UNITS_B[3] = '{8'hD0, 8'hA0, 8'h20};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(0, "R1 reset");

    // R2 R3 R4 R10: full sweep, odd units value ends transaction in same cycle
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 8; t++)
        for (int u = 0; u < 10; u++)
          for (int o = 0; o < 2; o++) begin
            logic [7:0] tb_, ub_;
            bit same;
            tb_ = TENS_B[s] | 8'(t);
            ub_ = UNITS_B[s] | 8'(u);
            same = (u % 2) == 1;
            step(1, o ? ub_ : tb_, 0, 0, "R4 half held");
            set_exp(s, t * 10 + u);
            step(1, o ? tb_ : ub_, same, 0, same ? "R10 commit with stop" : "R2 R3 commit");
            if (!same) step(0, 8'h00, 1, 0, "R4 stop after commit");
          end

    // R5: lone halves
    step(1, 8'hB3, 0, 0, "R5 lone tens");
    step(0, 8'h00, 1, 1, "R5 stop err");
    step(0, 8'h00, 0, 0, "R5 err one cycle");
    step(1, 8'h24, 1, 1, "R5 lone units with stop");
    step(0, 8'h00, 1, 0, "R5 empty stop");

    // R6: interleaved and same-kind
    step(1, 8'hB3, 0, 0, "R6 tens L");
    step(1, 8'h35, 0, 1, "R6 tens R displaces");
    exp_r = 52;
    step(1, 8'h22, 0, 0, "R6 units R commits");
    step(1, 8'hD1, 0, 0, "R6 units both");
    step(1, 8'hD2, 0, 1, "R6 units both repeat");
    exp_l = 2; exp_r = 2;
    step(1, 8'hE0, 1, 0, "R6 tens both commits");

    // R7: invalid units ignored
    step(1, 8'hE4, 0, 0, "R7 tens both");
    for (int a = 10; a < 16; a++) step(1, 8'hD0 | 8'(a), 0, 0, "R7 invalid units");
    exp_l = 41; exp_r = 41;
    step(1, 8'hD1, 0, 0, "R7 pair survives");
    step(1, 8'hAF, 1, 0, "R7 invalid no pending");

    // R11: unknown bytes keep pending half
    step(1, 8'hE2, 0, 0, "R11 tens both");
    step(1, 8'h00, 0, 0, "R11 byte 00");
    step(1, 8'hFF, 0, 0, "R11 byte FF");
    step(1, 8'hE8, 0, 0, "R11 byte E8");
    step(1, 8'h7B, 0, 0, "R11 byte 7B");
    step(1, 8'hF1, 0, 0, "R11 byte F1");
    exp_l = 25; exp_r = 25;
    step(1, 8'hD5, 1, 0, "R11 pair survives");

    // R9: mute sweep with pending half
    for (int c = 0; c < 4; c++) begin
      step(1, 8'h31, 0, 0, "R9 tens R");
      exp_ml = c[1]; exp_mr = c[0];
      step(1, 8'h7C | 8'(c), 0, 0, "R9 mute code");
      exp_r = 10 + c;
      step(1, 8'h20 | 8'(c), 1, 0, "R9 pair after mute");
    end

    // R8: clear with pending half
    step(1, 8'hB2, 0, 0, "R8 tens L");
    exp_l = 0; exp_r = 0; exp_ml = 0; exp_mr = 0;
    step(1, 8'hF0, 0, 0, "R8 clear");
    exp_l = 23;
    step(1, 8'hA3, 1, 0, "R8 pair after clear");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule